// File: doc/BRIEF.md
# Linked-load / conditional-store reservation monitor

This block lets one processor build an atomic read-modify-write from two ordinary memory operations. The processor first issues a linked load. The memory returns the word, and the monitor records a reservation on that word. Later the processor issues a conditional store. The store commits to memory only if nothing has written the reserved word in between. The conditional store's destination register then receives 1 on success and 0 on failure.

Writes are snooped on a configurable number of ports. By default, port 0 carries the processor's own ordinary stores and port 1 carries writes from the other agent that shares the memory. Addresses are compared as whole words, so the two byte-offset bits are ignored. The verdict on a conditional store is decided in the cycle the request is presented. The same cycle gates the memory write enable, so no other access can slip between the check and the write.

Top module: `rsv_monitor`

## Requirements
- R1: After reset no reservation is held, so a conditional store presented before any linked load fails with scPass=0 and memWrEn=0. A reset in the middle of a reservation also discards it.
- R2: A linked load records the word address reqAddr[ADDR_W-1:2]. A later conditional store to any byte address of that word passes if no write to the word has intervened, and it raises scPass=1 and memWrEn=1 in the same cycle as scReq.
- R3: A conditional store fails (scPass=0, memWrEn=0) when it targets a different word from the reservation, or when no reservation is valid.
- R4: A snooped write (snoopWr[i] with address field i of snoopAddr) to the reserved word clears the reservation, whichever port carries it and whatever its byte offset. A snooped write to any other word leaves the reservation intact.
- R5: A snooped write to the reserved word in the same cycle as the conditional store makes that store fail and suppresses memWrEn.
- R6: A snooped write to the linked word in the same cycle as the linked load leaves no reservation.
- R7: Every conditional store clears the reservation, whether it passes or fails, so an immediately repeated conditional store fails.
- R8: A new linked load replaces any earlier reservation. Afterwards a store to the old word fails and a store to the new word passes.
- R9: memWrEn is high only in a cycle with scReq, and it always equals scPass.
- R10: When llReq and scReq arrive together, the store is judged against the reservation held before that cycle. The load's new reservation is then held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| llReq | input | 1 | Linked load request |
| scReq | input | 1 | Conditional store request |
| reqAddr | input | ADDR_W | Byte address of the linked load or conditional store |
| snoopWr | input | NUM_SNOOP | Write strobe per snoop port (0: local stores, 1: other agent) |
| snoopAddr | input | NUM_SNOOP*ADDR_W | Byte addresses of the snooped writes, port i at bits [i*ADDR_W +: ADDR_W] |
| scPass | output | 1 | Conditional store verdict, the value returned to the destination register |
| memWrEn | output | 1 | Write enable to memory for the conditional store |

## Verification
scPass and memWrEn are combinational outputs. They are due in the same cycle as scReq, so the bench drives each request at a falling edge and samples the outputs 2 ns later, before the next rising edge. A reservation change from a linked load, a store or a snooped write takes effect at the rising edge that ends its request cycle. Each such change is therefore only checked through the verdict of a conditional store in a later cycle. The sweep pairs linked and conditional words, byte offsets and snoop patterns. It also compares memory in a model driven by memWrEn against an outcome worked out from the scenario alone.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch the request word as the new reservation
    logic scCheck;   // compare the request word against the reservation
  } rsvStrobe_t;

endpackage

// File: rtl/rsv_datapath.sv
module rsv_datapath
  import rsv_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_SNOOP = 2,
  parameter int WORD_LSB  = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  rsvStrobe_t                    strobe,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [NUM_SNOOP-1:0]          snoopWr,
  input  logic [NUM_SNOOP*ADDR_W-1:0]   snoopAddr,
  output logic [ADDR_W-WORD_LSB-1:0]    rsvWord,
  output logic                          rsvHit,
  output logic                          reqHit,
  output logic                          wordMatch
);

  localparam int WORD_W = ADDR_W - WORD_LSB;

  logic [WORD_W-1:0]    reqWord;
  logic [NUM_SNOOP-1:0] hitRsvVec;
  logic [NUM_SNOOP-1:0] hitReqVec;

  assign reqWord = reqAddr[ADDR_W-1:WORD_LSB];

  for (genvar gi = 0; gi < NUM_SNOOP; gi++) begin : g_snoop
    logic [WORD_W-1:0] snWord;
    assign snWord        = snoopAddr[gi*ADDR_W+WORD_LSB +: WORD_W];
    assign hitRsvVec[gi] = snoopWr[gi] && (snWord == rsvWord);
    assign hitReqVec[gi] = snoopWr[gi] && (snWord == reqWord);
  end

  assign rsvHit    = |hitRsvVec;
  assign reqHit    = |hitReqVec;
  assign wordMatch = strobe.scCheck && (reqWord == rsvWord);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rsvWord <= '0;
    end else if (strobe.capture) begin
      rsvWord <= reqWord;
    end
  end

endmodule

// File: rtl/rsv_control.sv
module rsv_control
  import rsv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       llReq,
  input  logic       scReq,
  input  logic       rsvHit,
  input  logic       reqHit,
  input  logic       wordMatch,
  output rsvStrobe_t strobe,
  output logic       rsvValid,
  output logic       scPass,
  output logic       memWrEn
);

  logic validNext;

  assign strobe.capture = llReq;
  assign strobe.scCheck = scReq;

  // verdict uses the reservation held before this cycle plus same-cycle snoops
  assign scPass  = scReq && rsvValid && wordMatch && !rsvHit;
  assign memWrEn = scPass;

  always_comb begin
    validNext = rsvValid;
    if (llReq) begin
      validNext = !reqHit;
    end else if (scReq || rsvHit) begin
      validNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rsvValid <= 1'b0;
    end else begin
      rsvValid <= validNext;
    end
  end

endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
  import rsv_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_SNOOP = 2,
  parameter int WORD_LSB  = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        llReq,
  input  logic                        scReq,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [NUM_SNOOP-1:0]        snoopWr,
  input  logic [NUM_SNOOP*ADDR_W-1:0] snoopAddr,
  output logic                        scPass,
  output logic                        memWrEn
);

  localparam int WORD_W = ADDR_W - WORD_LSB;

  rsvStrobe_t        strobe;
  logic [WORD_W-1:0] rsvWord;
  logic              rsvValid;
  logic              rsvHit;
  logic              reqHit;
  logic              wordMatch;

  rsv_datapath #(
    .ADDR_W(ADDR_W), .NUM_SNOOP(NUM_SNOOP), .WORD_LSB(WORD_LSB)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .snoopWr(snoopWr), .snoopAddr(snoopAddr), .rsvWord(rsvWord),
    .rsvHit(rsvHit), .reqHit(reqHit), .wordMatch(wordMatch)
  );

  rsv_control i_control (
    .clk(clk), .rstN(rstN), .llReq(llReq), .scReq(scReq),
    .rsvHit(rsvHit), .reqHit(reqHit), .wordMatch(wordMatch),
    .strobe(strobe), .rsvValid(rsvValid), .scPass(scPass), .memWrEn(memWrEn)
  );

endmodule

// File: rtl/rsv_monitor_chk.sv
module rsv_monitor_chk #(
  parameter int ADDR_W    = 32,
  parameter int NUM_SNOOP = 2,
  parameter int WORD_LSB  = 2
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        llReq,
  input logic                        scReq,
  input logic [ADDR_W-1:0]           reqAddr,
  input logic [NUM_SNOOP-1:0]        snoopWr,
  input logic [NUM_SNOOP*ADDR_W-1:0] snoopAddr,
  input logic                        scPass,
  input logic                        memWrEn,
  input logic                        rsvValid,
  input logic [ADDR_W-WORD_LSB-1:0]  rsvWord
);

  localparam int WORD_W = ADDR_W - WORD_LSB;

  logic hitOld;
  logic hitNew;

  always_comb begin
    hitOld = 1'b0;
    hitNew = 1'b0;
    for (int i = 0; i < NUM_SNOOP; i++) begin
      if (snoopWr[i] && snoopAddr[i*ADDR_W+WORD_LSB +: WORD_W] == rsvWord) hitOld = 1'b1;
      if (snoopWr[i] && snoopAddr[i*ADDR_W+WORD_LSB +: WORD_W] == reqAddr[ADDR_W-1:WORD_LSB]) hitNew = 1'b1;
    end
  end

  AST_PASS_NEEDS_RSV: assert property (@(posedge clk) disable iff (!rstN)
    scPass |-> rsvValid && reqAddr[ADDR_W-1:WORD_LSB] == rsvWord); // R3

  AST_WREN_GATED: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> scReq && scPass); // R9

  AST_SC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    scReq && !llReq |=> !rsvValid); // R7

  AST_SNOOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    hitOld && !llReq |=> !rsvValid); // R4

  AST_SAME_CYCLE_SC_HIT: assert property (@(posedge clk) disable iff (!rstN)
    scReq && hitOld |-> !scPass && !memWrEn); // R5

  AST_LL_HIT_NO_RSV: assert property (@(posedge clk) disable iff (!rstN)
    llReq && hitNew |=> !rsvValid); // R6

  AST_LL_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    llReq && !hitNew |=> rsvValid && rsvWord == $past(reqAddr[ADDR_W-1:WORD_LSB])); // R8

endmodule

bind rsv_monitor rsv_monitor_chk #(
  .ADDR_W(ADDR_W), .NUM_SNOOP(NUM_SNOOP), .WORD_LSB(WORD_LSB)
) i_chk (
  .clk(clk), .rstN(rstN), .llReq(llReq), .scReq(scReq), .reqAddr(reqAddr),
  .snoopWr(snoopWr), .snoopAddr(snoopAddr), .scPass(scPass), .memWrEn(memWrEn),
  .rsvValid(rsvValid), .rsvWord(rsvWord)
);

// File: tb/test_rsv_monitor.sv
module test_rsv_monitor;

  localparam int AW  = 6;
  localparam int NS  = 2;
  localparam int LSB = 2;
  localparam int WW  = AW - LSB;
  localparam int NW  = 1 << WW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rstN;
  logic            llReq;
  logic            scReq;
  logic [AW-1:0]   reqAddr;
  logic [NS-1:0]   snoopWr;
  logic [NS*AW-1:0] snoopAddr;
  logic            scPass;
  logic            memWrEn;

  rsv_monitor #(.ADDR_W(AW), .NUM_SNOOP(NS), .WORD_LSB(LSB)) i_rsv_monitor (
    .clk(clk), .rstN(rstN), .llReq(llReq), .scReq(scReq), .reqAddr(reqAddr),
    .snoopWr(snoopWr), .snoopAddr(snoopAddr), .scPass(scPass), .memWrEn(memWrEn)
  );

  int checks = 0;
  int fails  = 0;
  int stamp  = 1;
  logic [31:0] mem [NW];
  logic [31:0] lastScData;
  bit          mValid;
  logic [WW-1:0] mWord;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one request cycle: drive at falling edge, sample before the rising edge
  task automatic step(input bit ll, input bit sc, input logic [AW-1:0] a,
                      input logic [1:0] sw, input logic [AW-1:0] a0,
                      input logic [AW-1:0] a1, input string tag);
    bit hitOld, hitReq, expPass;
    @(negedge clk);
    llReq = ll; scReq = sc; reqAddr = a; snoopWr = sw; snoopAddr = {a1, a0};
    hitOld  = (sw[0] && a0[AW-1:LSB] == mWord) || (sw[1] && a1[AW-1:LSB] == mWord);
    hitReq  = (sw[0] && a0[AW-1:LSB] == a[AW-1:LSB]) || (sw[1] && a1[AW-1:LSB] == a[AW-1:LSB]);
    expPass = sc && mValid && (a[AW-1:LSB] == mWord) && !hitOld;
    #2;
    check(scPass == expPass, tag, 32'(scPass), 32'(expPass));
    check(memWrEn == expPass, "R9", 32'(memWrEn), 32'(expPass));
    if (sw[0]) begin mem[a0[AW-1:LSB]] = 32'hA000_0000 + 32'(stamp); stamp++; end
    if (sw[1]) begin mem[a1[AW-1:LSB]] = 32'hB000_0000 + 32'(stamp); stamp++; end
    if (memWrEn) begin
      lastScData = 32'h5C00_0000 + 32'(stamp);
      mem[a[AW-1:LSB]] = lastScData;
      stamp++;
    end
    if (ll) begin
      mValid = !hitReq;
      mWord  = a[AW-1:LSB];
    end else if (sc || hitOld) begin
      mValid = 1'b0;
    end
    @(posedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; llReq = 0; scReq = 0; snoopWr = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mValid = 1'b0;
  endtask

  function automatic logic [AW-1:0] wa(input int w, input int off);
    return AW'(w * 4 + off);
  endfunction

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; llReq = 0; scReq = 0; reqAddr = '0; snoopWr = '0; snoopAddr = '0;
    mValid = 0; mWord = '0; lastScData = '0;
    for (int i = 0; i < NW; i++) mem[i] = 32'(i);
    doReset();

    // R1: no reservation out of reset
    step(0, 1, wa(0, 0), 2'b00, '0, '0, "R1");
    step(1, 0, wa(2, 0), 2'b00, '0, '0, "R1");
    doReset();
    step(0, 1, wa(2, 0), 2'b00, '0, '0, "R1");

    // sweep: linked word, store word, byte offset, snoop pattern
    for (int llW = 0; llW < 4; llW++) begin
      for (int scW = 0; scW < 4; scW++) begin
        for (int off = 0; off < 4; off++) begin
          for (int s = 0; s < 6; s++) begin
            logic [1:0]    sw;
            logic [AW-1:0] a0, a1;
            logic [31:0]   oldVal;
            bit            expOk;
            a0 = '0; a1 = '0; sw = 2'b00;
            case (s)
              1: begin sw = 2'b01; a0 = wa(llW, off); end
              2: begin sw = 2'b10; a1 = wa(llW, 3 - off); end
              3: begin sw = 2'b10; a1 = wa(llW + 8, off); end
              4: begin sw = 2'b01; a0 = wa(llW + 4, 0); end
              5: begin sw = 2'b11; a0 = wa(llW + 8, 1); a1 = wa(llW + 12, 2); end
              default: ;
            endcase
            step(1, 0, wa(llW, off ^ 1), 2'b00, '0, '0, "R2");
            step(0, 0, '0, sw, a0, a1, "R4");
            oldVal = mem[scW];
            expOk  = (llW == scW) && (s != 1) && (s != 2);
            step(0, 1, wa(scW, off), 2'b00, '0, '0, (llW == scW) ? "R4" : "R3");
            check(mem[scW] == (expOk ? lastScData : oldVal), expOk ? "R2" : "R3",
                  mem[scW], expOk ? lastScData : oldVal);
            step(0, 1, wa(scW, off), 2'b00, '0, '0, "R7");
          end
        end
      end
    end

    // R5: snoop to the reserved word in the store's own cycle
    step(1, 0, wa(5, 0), 2'b00, '0, '0, "R5");
    step(0, 1, wa(5, 2), 2'b10, '0, wa(5, 1), "R5");
    step(1, 0, wa(5, 0), 2'b00, '0, '0, "R5");
    step(0, 1, wa(5, 2), 2'b11, wa(6, 0), wa(7, 0), "R5");

    // R6: snoop to the linked word in the load's own cycle
    step(1, 0, wa(6, 0), 2'b01, wa(6, 3), '0, "R6");
    step(0, 1, wa(6, 0), 2'b00, '0, '0, "R6");

    // R8: replacement of the reservation
    step(1, 0, wa(1, 0), 2'b00, '0, '0, "R8");
    step(1, 0, wa(2, 0), 2'b00, '0, '0, "R8");
    step(0, 1, wa(1, 0), 2'b00, '0, '0, "R8");
    step(1, 0, wa(1, 0), 2'b00, '0, '0, "R8");
    step(1, 0, wa(2, 0), 2'b00, '0, '0, "R8");
    step(0, 1, wa(2, 1), 2'b00, '0, '0, "R8");

    // R10: load and store together
    step(1, 0, wa(3, 0), 2'b00, '0, '0, "R10");
    step(1, 1, wa(3, 0), 2'b00, '0, '0, "R10");
    step(0, 1, wa(3, 0), 2'b00, '0, '0, "R10");
    step(1, 1, wa(4, 0), 2'b00, '0, '0, "R10");
    step(0, 1, wa(4, 0), 2'b00, '0, '0, "R10");

    @(negedge clk);
    llReq = 0; scReq = 0; snoopWr = '0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule